// File: doc/BRIEF.md
# Synthesizer divider configuration loader

This block holds the programming state of a frequency synthesizer: a 9-bit feedback divide value, a 2-bit output divide select and a 2-bit test selector. It can be written in two ways. In parallel mode a strobe pin either lets the divider pins flow straight through or freezes them. In serial mode a three-wire port (data, clock, update) fills a 14-bit shift register. An update line copies the shift register into the active values, and while that line stays high the copy is transparent.

All control and data inputs are brought into one system clock through two-flop synchronizers. Edges are found by comparing each synchronized sample with the one before it. The block also drives a test pin. Depending on the test selector, the pin shows a constant low, the serial data input, the feedback-divider tap or the synthesized clock. In parallel mode the pin is held low. A master reset input only passes on to the downstream dividers. The loaded configuration is not affected by it.

Top module: `divcfg_loader`

## Requirements
- R1: After power-up reset, with the strobe pin held high, the outputs read m_val = 24, n_sel = 00, t_sel = 00 and test_out = 0.
- R2: While par_strobe is high, each rising edge of ser_clk shifts ser_dat into a 14-bit register. A frame is sent as T1, T0, one null slot, N1, N0, then M8 down to M0, so M0 is the last bit in.
- R3: A rising edge of ser_upd, with par_strobe high, copies the last 14 shifted bits into m_val, n_sel and t_sel.
- R4: After ser_upd falls, more serial shifts leave m_val, n_sel and t_sel unchanged.
- R5: While ser_upd stays high in serial mode, m_val, n_sel and t_sel follow the shift register after every rising ser_clk edge.
- R6: While par_strobe is low, m_val follows par_m and n_sel follows par_n. n_sel code 00, 01, 10, 11 selects divide by 1, 2, 4, 8.
- R7: A rising edge of par_strobe freezes the parallel values. Later changes on par_m or par_n do not reach the outputs.
- R8: test_out shows, by t_sel: 00 low, 01 ser_dat, 10 mdiv_tap, 11 synth_clk. It is low whenever par_strobe is low.
- R9: The bit sent in the null slot has no effect on m_val, n_sel or t_sel.
- R10: div_rst follows mr. Asserting mr leaves m_val, n_sel and t_sel unchanged.
- R11: An input change reaches the configuration outputs within four system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-up reset, active low |
| mr | input | 1 | Master reset for downstream dividers, active high |
| par_strobe | input | 1 | Low: parallel transparent; rising: latch; high: serial mode |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel output divide select |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data |
| ser_upd | input | 1 | Serial update: rising copies, high transparent, falling freezes |
| mdiv_tap | input | 1 | Feedback-divider output, test observation only |
| synth_clk | input | 1 | Synthesized clock, test observation only |
| m_val | output | 9 | Active feedback divide value |
| n_sel | output | 2 | Active output divide select |
| t_sel | output | 2 | Active test selector |
| test_out | output | 1 | Test multiplexer output |
| div_rst | output | 1 | Synchronized divider reset |

## Verification
A corrupted shift register stays hidden until an update. After that it shows at m_val, n_sel and t_sel within four cycles, and in the transparent phase it shows after every serial clock. A wrong load source or a missed latch edge puts the wrong parallel or serial values on the outputs within four cycles of the strobe or update change. A wrong test selector or mode shows on test_out at once for the two clock taps, and within two cycles for the serial data tap.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int M_W     = 9;
    localparam int N_W     = 2;
    localparam int T_W     = 2;
    localparam int NULL_W  = 1;
    localparam int FRAME_W = T_W + NULL_W + N_W + M_W;

    typedef struct packed {
        logic [T_W-1:0] t;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } cfg_t;

    typedef enum logic [1:0] {
        TEST_LOW   = 2'b00,
        TEST_SDAT  = 2'b01,
        TEST_MDIV  = 2'b10,
        TEST_SYNTH = 2'b11
    } test_sel_e;

    typedef enum logic [1:0] {
        LD_HOLD = 2'b00,
        LD_PAR  = 2'b01,
        LD_SER  = 2'b10
    } load_src_e;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef logic [STAGES-1:0][W-1:0] chain_t;

    chain_t chain_d;
    chain_t chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= RST_VAL;
            end
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/cfg_shift.sv
module cfg_shift
    import cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic sclk,
    input  logic sdat,
    output cfg_t frame_o
);

    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic               sclk_prev;
    } shift_state_t;

    shift_state_t s_d;
    shift_state_t s_q;
    logic         sclk_rise;

    always_comb begin
        s_d           = s_q;
        s_d.sclk_prev = sclk;
        sclk_rise     = sclk & ~s_q.sclk_prev;
        if (shift_en && sclk_rise) begin
            s_d.sr = {s_q.sr[FRAME_W-2:0], sdat};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // Field positions follow the transmit order: M0 last, the null slot
    // between the output select and the test selector.
    always_comb begin
        frame_o.m = s_q.sr[M_W-1:0];
        frame_o.n = s_q.sr[M_W+N_W-1:M_W];
        frame_o.t = s_q.sr[FRAME_W-1 -: T_W];
    end

    // R2: a qualified serial clock edge puts the sampled data bit at the tail
    p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && sclk && !s_q.sclk_prev) |=> (s_q.sr[0] == $past(sdat)));

    // R2: without a qualified edge the register keeps its contents
    p_shift_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_en && sclk && !s_q.sclk_prev) |=> $stable(s_q.sr));

endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
    import cfg_pkg::*;
#(
    parameter logic [M_W-1:0] M_RST = 9'd24,
    parameter logic [N_W-1:0] N_RST = '0,
    parameter logic [T_W-1:0] T_RST = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           strobe,
    input  logic           upd,
    input  cfg_t           frame_i,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    output cfg_t           cfg_o
);

    cfg_t      cfg_d;
    cfg_t      cfg_q;
    load_src_e src;

    always_comb begin
        if (!strobe) begin
            src = LD_PAR;
        end else if (upd) begin
            src = LD_SER;
        end else begin
            src = LD_HOLD;
        end
    end

    always_comb begin
        cfg_d = cfg_q;
        case (src)
            LD_PAR: begin
                cfg_d.m = par_m;
                cfg_d.n = par_n;
            end
            LD_SER:  cfg_d = frame_i;
            default: cfg_d = cfg_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.m <= M_RST;
            cfg_q.n <= N_RST;
            cfg_q.t <= T_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

    // R6: parallel mode passes the pins through one cycle later
    p_par_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> (cfg_q.m == $past(par_m) && cfg_q.n == $past(par_n)));

    // R3, R5: update level in serial mode copies the shift register
    p_ser_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && upd) |=> (cfg_q == $past(frame_i)));

    // R4, R7: serial mode without update keeps everything
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !upd) |=> $stable(cfg_q));

    // R6: parallel mode never touches the test selector
    p_par_keeps_t_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(cfg_q.t));

endmodule

// File: rtl/cfg_test_mux.sv
module cfg_test_mux
    import cfg_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           serial_mode,
    input  logic [T_W-1:0] sel,
    input  logic           sdat,
    input  logic           mdiv_tap,
    input  logic           synth_clk,
    output logic           test_o
);

    test_sel_e sel_e;
    logic      tap;

    always_comb begin
        sel_e = test_sel_e'(sel);
        case (sel_e)
            TEST_SDAT:  tap = sdat;
            TEST_MDIV:  tap = mdiv_tap;
            TEST_SYNTH: tap = synth_clk;
            default:    tap = 1'b0;
        endcase
        test_o = serial_mode & tap;
    end

    // R8: parallel mode keeps the test pin low
    p_test_par_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !serial_mode |-> !test_o);

    // R8: selector 00 gives a constant low
    p_test_sel_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b00) |-> !test_o);

    // R8: selector 10 shows the divider tap in serial mode
    p_test_mdiv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (serial_mode && sel == 2'b10) |-> (test_o == mdiv_tap));

endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader
    import cfg_pkg::*;
#(
    parameter int             SYNC_STAGES = 2,
    parameter logic [M_W-1:0] M_DEFAULT   = 9'd24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mr,
    input  logic           par_strobe,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    input  logic           ser_clk,
    input  logic           ser_dat,
    input  logic           ser_upd,
    input  logic           mdiv_tap,
    input  logic           synth_clk,
    output logic [M_W-1:0] m_val,
    output logic [N_W-1:0] n_sel,
    output logic [T_W-1:0] t_sel,
    output logic           test_out,
    output logic           div_rst
);

    localparam int CTRL_W   = 5;
    localparam int SYNC_W   = M_W + N_W + CTRL_W;
    localparam int STROBE_I = M_W + N_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = SYNC_W'(1) << STROBE_I;

    logic [SYNC_W-1:0] raw_bus;
    logic [SYNC_W-1:0] sync_bus;

    logic           strobe_s;
    logic           sclk_s;
    logic           sdat_s;
    logic           upd_s;
    logic           mr_s;
    logic [M_W-1:0] par_m_s;
    logic [N_W-1:0] par_n_s;

    cfg_t frame;
    cfg_t cfg;

    assign raw_bus = {mr, ser_upd, ser_dat, ser_clk, par_strobe, par_n, par_m};

    cfg_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_bus),
        .dout  (sync_bus)
    );

    always_comb begin
        par_m_s  = sync_bus[M_W-1:0];
        par_n_s  = sync_bus[M_W+N_W-1:M_W];
        strobe_s = sync_bus[STROBE_I];
        sclk_s   = sync_bus[STROBE_I+1];
        sdat_s   = sync_bus[STROBE_I+2];
        upd_s    = sync_bus[STROBE_I+3];
        mr_s     = sync_bus[STROBE_I+4];
    end

    cfg_shift i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (strobe_s),
        .sclk     (sclk_s),
        .sdat     (sdat_s),
        .frame_o  (frame)
    );

    cfg_regs #(
        .M_RST (M_DEFAULT),
        .N_RST ('0),
        .T_RST ('0)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (strobe_s),
        .upd     (upd_s),
        .frame_i (frame),
        .par_m   (par_m_s),
        .par_n   (par_n_s),
        .cfg_o   (cfg)
    );

    cfg_test_mux i_tmux (
        .clk         (clk),
        .rst_n       (rst_n),
        .serial_mode (strobe_s),
        .sel         (cfg.t),
        .sdat        (sdat_s),
        .mdiv_tap    (mdiv_tap),
        .synth_clk   (synth_clk),
        .test_o      (test_out)
    );

    assign m_val   = cfg.m;
    assign n_sel   = cfg.n;
    assign t_sel   = cfg.t;
    assign div_rst = mr_s;

    // R10: the divider reset never disturbs the loaded configuration
    p_mr_keeps_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mr_s && strobe_s && !upd_s) |=> $stable({m_val, n_sel, t_sel}));

endmodule

// File: tb/test_divcfg_loader.sv
module test_divcfg_loader;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mr = 1'b0;
    logic       par_strobe = 1'b1;
    logic [8:0] par_m = '0;
    logic [1:0] par_n = '0;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic       ser_upd = 1'b0;
    logic       mdiv_tap = 1'b0;
    logic       synth_clk = 1'b0;
    logic [8:0] m_val;
    logic [1:0] n_sel;
    logic [1:0] t_sel;
    logic       test_out;
    logic       div_rst;

    int checks = 0;
    int errors = 0;
    logic [13:0] model = '0;
    int exp_m = 24;
    int exp_n = 0;
    int exp_t = 0;

    always #4 clk = ~clk;

    divcfg_loader i_divcfg_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .mr         (mr),
        .par_strobe (par_strobe),
        .par_m      (par_m),
        .par_n      (par_n),
        .ser_clk    (ser_clk),
        .ser_dat    (ser_dat),
        .ser_upd    (ser_upd),
        .mdiv_tap   (mdiv_tap),
        .synth_clk  (synth_clk),
        .m_val      (m_val),
        .n_sel      (n_sel),
        .t_sel      (t_sel),
        .test_out   (test_out),
        .div_rst    (div_rst)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_cfg(input string req);
        check({req, " m"}, int'(m_val), exp_m);
        check({req, " n"}, int'(n_sel), exp_n);
        check({req, " t"}, int'(t_sel), exp_t);
    endtask

    task automatic shift_bit(input logic b);
        ser_dat = b;
        wait_cyc(3);
        ser_clk = 1'b1;
        wait_cyc(3);
        ser_clk = 1'b0;
        wait_cyc(3);
        model = {model[12:0], b};
    endtask

    task automatic send_frame(input int t, input int n, input int m, input logic nb);
        logic [13:0] bits;
        bits = {2'(t), nb, 2'(n), 9'(m)};
        for (int i = 13; i >= 0; i--) begin
            shift_bit(bits[i]);
        end
    endtask

    task automatic load_frame(input int t, input int n, input int m, input logic nb);
        send_frame(t, n, m, nb);
        ser_upd = 1'b1;
        wait_cyc(5);
        ser_upd = 1'b0;
        wait_cyc(5);
        exp_t = t;
        exp_n = n;
        exp_m = m;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state with the strobe held high
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(6);
        check_cfg("R1");
        check("R1 test", int'(test_out), 0);

        // R6: parallel pass-through sweep over all output selects
        par_strobe = 1'b0;
        for (int k = 0; k < 32; k++) begin
            par_m = 9'((k * 53 + 7) % 512);
            par_n = 2'(k % 4);
            wait_cyc(5);
            check("R6 m", int'(m_val), (k * 53 + 7) % 512);
            check("R6 n", int'(n_sel), k % 4);
        end
        // R8: parallel mode holds the test pin low
        synth_clk = 1'b1;
        mdiv_tap = 1'b1;
        wait_cyc(1);
        check("R8 par low", int'(test_out), 0);
        synth_clk = 1'b0;
        mdiv_tap = 1'b0;

        // R7: strobe rise latches, later pin changes ignored
        par_m = 9'd300;
        par_n = 2'd2;
        wait_cyc(5);
        par_strobe = 1'b1;
        wait_cyc(5);
        par_m = 9'd5;
        par_n = 2'd1;
        wait_cyc(6);
        exp_m = 300;
        exp_n = 2;
        exp_t = 0;
        check_cfg("R7");

        // R2, R3, R9: serial frames with both null-slot values
        for (int f = 0; f < 8; f++) begin
            int t = f % 4;
            int n = (f * 3 + 1) % 4;
            int m = (f * 97 + 11) % 512;
            send_frame(t, n, m, 1'(f % 2));
            check_cfg("R4 before update");
            ser_upd = 1'b1;
            wait_cyc(5);
            exp_t = t;
            exp_n = n;
            exp_m = m;
            check_cfg("R3 R9 load");
            ser_upd = 1'b0;
            wait_cyc(5);
        end

        // R4: shifting after the update fell leaves values frozen
        shift_bit(1'b1);
        shift_bit(1'b0);
        shift_bit(1'b1);
        check_cfg("R4 frozen");

        // R5: transparent phase follows every serial clock
        ser_upd = 1'b1;
        wait_cyc(5);
        begin
            logic [13:0] bits;
            bits = {2'd2, 1'b1, 2'd3, 9'd421};
            for (int i = 13; i >= 0; i--) begin
                shift_bit(bits[i]);
                wait_cyc(2);
                check("R5 m", int'(m_val), int'(model[8:0]));
                check("R5 n", int'(n_sel), int'(model[10:9]));
                check("R5 t", int'(t_sel), int'(model[13:12]));
            end
        end
        ser_upd = 1'b0;
        wait_cyc(5);
        exp_t = 2;
        exp_n = 3;
        exp_m = 421;
        shift_bit(1'b0);
        shift_bit(1'b1);
        check_cfg("R4 after transparent");

        // R10: master reset passes on and leaves configuration alone
        mr = 1'b1;
        wait_cyc(5);
        check("R10 div_rst high", int'(div_rst), 1);
        check_cfg("R10 during");
        mr = 1'b0;
        wait_cyc(5);
        check("R10 div_rst low", int'(div_rst), 0);
        check_cfg("R10 after");

        // R8: test selector decode
        load_frame(0, 0, 24, 1'b0);
        synth_clk = 1'b1;
        mdiv_tap = 1'b1;
        ser_dat = 1'b1;
        wait_cyc(4);
        check("R8 sel00", int'(test_out), 0);
        synth_clk = 1'b0;
        mdiv_tap = 1'b0;

        load_frame(1, 1, 100, 1'b0);
        ser_dat = 1'b1;
        wait_cyc(4);
        check("R8 sel01 high", int'(test_out), 1);
        ser_dat = 1'b0;
        wait_cyc(4);
        check("R8 sel01 low", int'(test_out), 0);

        load_frame(2, 2, 200, 1'b1);
        mdiv_tap = 1'b1;
        #1;
        check("R8 sel10 high", int'(test_out), 1);
        mdiv_tap = 1'b0;
        #1;
        check("R8 sel10 low", int'(test_out), 0);

        load_frame(3, 3, 511, 1'b0);
        synth_clk = 1'b1;
        #1;
        check("R8 sel11 high", int'(test_out), 1);
        synth_clk = 1'b0;
        #1;
        check("R8 sel11 low", int'(test_out), 0);
        check_cfg("R3 last frame");

        // R8: parallel mode overrides a clock selector
        synth_clk = 1'b1;
        par_m = 9'd77;
        par_n = 2'd0;
        par_strobe = 1'b0;
        wait_cyc(5);
        check("R8 forced low", int'(test_out), 0);
        check("R6 t kept", int'(t_sel), 3);
        check("R6 m final", int'(m_val), 77);

        // R11: parallel change visible within four cycles
        par_m = 9'd123;
        wait_cyc(4);
        check("R11 latency", int'(m_val), 123);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule